// File: doc/BRIEF.md
# Interlaced Sync Timing Unit

This block keeps the horizontal and vertical timing of an interlaced television raster on the 27 MHz double-pixel clock. With the master strap high it counts clocks within a line and lines within a frame. It drives active-low horizontal and vertical sync for a 525-line or a 625-line raster. With the strap low the sync pins are inputs. The same counters then lock to the incoming falling edges, and each vertical edge is classified to recover the field.

A two-bit mode input selects the raster standard or a sleep state. Sleep only turns off the encoder-enable output. The counters keep running on the last standard chosen, so the downstream clocks and timing never stop. The position outputs are sample number, line number, field parity and horizontal and vertical blanking flags. They feed the encoder datapath.

Top module: `sync_timer`

## Requirements
- R1: `modeSel` 2'b11 and 2'b01 select the 525-line raster (line of `LINE_CLKS_525` clocks, `FRAME_LINES_525` lines). 2'b10 selects the 625-line raster (`LINE_CLKS_625` clocks, `FRAME_LINES_625` lines). `encEnable` is 1 in all three.
- R2: `modeSel` 2'b00 is sleep. `encEnable` is 0 and the counters keep running on the standard that was active before sleep.
- R3: In master mode `sampleNum` counts 0 to line length minus 1 and then wraps. `hsyncOut` is 0 exactly while `sampleNum` < `HSYNC_CLKS`.
- R4: In master mode `lineNum` advances when `sampleNum` wraps and goes from frame lines minus 1 to 0. `evenField` becomes 0 at line 0, sample 0. `evenField` becomes 1 at line N/2, sample L/2, where N is the number of lines in a frame, L is the line length, and integer division is used.
- R5: In master mode `vsyncOut` is 0 for `VSYNC_LINES` whole lines from line 0, sample 0. It is also 0 for `VSYNC_LINES`×L clocks starting at line N/2, sample L/2.
- R6: `hBlank` is 1 while `sampleNum` < `HBLANK_CLKS`. `vBlank` is 1 while `lineNum` < `VBLANK_LINES`, or while N/2 ≤ `lineNum` < N/2 + `VBLANK_LINES`.
- R7: With `masterSel`=1, `syncOe` is 1. With `masterSel`=0, `syncOe` is 0 and both sync outputs stay at 1.
- R8: In slave mode, the clock edge that first samples `hsyncIn` low makes `sampleNum` 0 and advances `lineNum` by one, wrapping at frame lines minus 1. Between such edges `sampleNum` counts up by one per clock.
- R9: In slave mode, a falling `vsyncIn` sampled on the same edge as a falling `hsyncIn` sets `lineNum` to 0 and `evenField` to 0.
- R10: In slave mode, a falling `vsyncIn` sampled when the shown `sampleNum` s satisfies L/4 ≤ s < 3L/4 sets `lineNum` to N/2 and `evenField` to 1.
- R11: In slave mode, a falling `vsyncIn` sampled when s < L/4 sets `lineNum` to 0. When s ≥ 3L/4 it sets `lineNum` to N−1, so the next horizontal edge starts line 0. In both cases `evenField` becomes 0.
- R12: While `rstN` is 0, `sampleNum`, `lineNum` and `evenField` are 0 and the 525-line standard is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Standard / sleep select |
| masterSel | input | 1 | 1 = drive sync, 0 = follow sync inputs |
| hsyncIn | input | 1 | Active-low horizontal sync from outside (slave) |
| vsyncIn | input | 1 | Active-low vertical sync from outside (slave) |
| hsyncOut | output | 1 | Active-low horizontal sync (master) |
| vsyncOut | output | 1 | Active-low vertical sync (master) |
| syncOe | output | 1 | Output enable for the sync pin drivers |
| sampleNum | output | SAMPLE_W | Clock position within the line |
| lineNum | output | LINE_W | Line position within the frame |
| evenField | output | 1 | Field parity, 1 = second field |
| hBlank | output | 1 | Horizontal blanking interval |
| vBlank | output | 1 | Vertical blanking interval |
| encEnable | output | 1 | Encoder path enable, 0 in sleep |

## Verification
The assertions assume that the strap and the mode change only between clock edges. They also assume that in slave mode each vertical falling edge follows a horizontal edge that has already restarted the line. The stimulus changes modes only at frame boundaries. It drives the slave sync pins from a line generator that always produces a horizontal edge at the start of each line. It keeps vertical sync low for one line length and follows every vertical edge with a line without one, so no two vertical edges overlap. Vertical edge positions are drawn at random across the whole line and also placed on each classification boundary.

// File: rtl/sync_pkg.sv
package sync_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_PALM  = 2'b01,
    MODE_PAL   = 2'b10,
    MODE_NTSC  = 2'b11
  } modeSel_e;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } rasterStd_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_MID  = 2'd1,
    SEL_LAST = 2'd2
  } lineSel_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic     sampleClr;
    logic     lineInc;
    logic     lineLoad;
    lineSel_e lineSel;
    logic     fieldSet;
    logic     fieldVal;
  } syncStrb_t;

endpackage

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import sync_pkg::*;
#(
  parameter int LINE_CLKS_525   = 1716,
  parameter int LINE_CLKS_625   = 1728,
  parameter int FRAME_LINES_525 = 525,
  parameter int FRAME_LINES_625 = 625,
  parameter int SAMPLE_W        = 11,
  parameter int LINE_W          = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                masterSel,
  input  logic                hsyncIn,
  input  logic                vsyncIn,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic [LINE_W-1:0]   lineR,
  output syncStrb_t           strb,
  output logic [SAMPLE_W-1:0] lineLast,
  output logic [SAMPLE_W-1:0] lineHalf,
  output logic [LINE_W-1:0]   frameLast,
  output logic [LINE_W-1:0]   fieldMid,
  output logic                encEnable
);

  localparam logic [SAMPLE_W-1:0] LAST_525 = SAMPLE_W'(LINE_CLKS_525 - 1);
  localparam logic [SAMPLE_W-1:0] LAST_625 = SAMPLE_W'(LINE_CLKS_625 - 1);
  localparam logic [SAMPLE_W-1:0] HALF_525 = SAMPLE_W'(LINE_CLKS_525 / 2);
  localparam logic [SAMPLE_W-1:0] HALF_625 = SAMPLE_W'(LINE_CLKS_625 / 2);
  localparam logic [SAMPLE_W-1:0] QTR_525  = SAMPLE_W'(LINE_CLKS_525 / 4);
  localparam logic [SAMPLE_W-1:0] QTR_625  = SAMPLE_W'(LINE_CLKS_625 / 4);
  localparam logic [SAMPLE_W-1:0] TQ_525   = SAMPLE_W'((3 * LINE_CLKS_525) / 4);
  localparam logic [SAMPLE_W-1:0] TQ_625   = SAMPLE_W'((3 * LINE_CLKS_625) / 4);
  localparam logic [LINE_W-1:0]   FL_525   = LINE_W'(FRAME_LINES_525 - 1);
  localparam logic [LINE_W-1:0]   FL_625   = LINE_W'(FRAME_LINES_625 - 1);
  localparam logic [LINE_W-1:0]   MID_525  = LINE_W'(FRAME_LINES_525 / 2);
  localparam logic [LINE_W-1:0]   MID_625  = LINE_W'(FRAME_LINES_625 / 2);
  localparam int                  N_PINS   = 2;

  rasterStd_e          stdR, stdNext;
  logic [N_PINS-1:0]   pinIn, pinFall;
  logic                hsFall, vsFall, lineEnd;
  logic [SAMPLE_W-1:0] quarter, threeQ;

  // falling-edge detectors for the two sync inputs
  assign pinIn = {vsyncIn, hsyncIn};
  for (genvar g = 0; g < N_PINS; g++) begin : g_edge
    logic prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevQ <= 1'b1;
      else       prevQ <= pinIn[g];
    end
    assign pinFall[g] = prevQ & ~pinIn[g];
  end
  assign hsFall = pinFall[0];
  assign vsFall = pinFall[1];

  // standard select; sleep holds the previous standard
  always_comb begin
    unique case (modeSel)
      MODE_PAL:             stdNext = STD_625;
      MODE_NTSC, MODE_PALM: stdNext = STD_525;
      default:              stdNext = stdR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stdR <= STD_525;
    else       stdR <= stdNext;
  end

  assign lineLast  = (stdR == STD_625) ? LAST_625 : LAST_525;
  assign lineHalf  = (stdR == STD_625) ? HALF_625 : HALF_525;
  assign quarter   = (stdR == STD_625) ? QTR_625  : QTR_525;
  assign threeQ    = (stdR == STD_625) ? TQ_625   : TQ_525;
  assign frameLast = (stdR == STD_625) ? FL_625   : FL_525;
  assign fieldMid  = (stdR == STD_625) ? MID_625  : MID_525;
  assign encEnable = (modeSel != MODE_SLEEP);

  assign lineEnd = (sampleR >= lineLast);

  always_comb begin
    strb = '0;
    strb.lineSel = SEL_ZERO;
    if (masterSel) begin
      strb.sampleClr = lineEnd;
      strb.lineInc   = lineEnd;
      if (lineEnd && (lineR >= frameLast)) begin
        strb.lineLoad = 1'b1;
        strb.lineSel  = SEL_ZERO;
        strb.fieldSet = 1'b1;
        strb.fieldVal = 1'b0;
      end
      if ((lineR == fieldMid) && (sampleR == lineHalf - 1'b1)) begin
        strb.fieldSet = 1'b1;
        strb.fieldVal = 1'b1;
      end
    end else begin
      strb.sampleClr = hsFall | lineEnd;
      strb.lineInc   = hsFall;
      if (vsFall) begin
        strb.lineLoad = 1'b1;
        strb.fieldSet = 1'b1;
        if (hsFall || (sampleR < quarter)) begin
          strb.lineSel  = SEL_ZERO;
          strb.fieldVal = 1'b0;
        end else if (sampleR >= threeQ) begin
          strb.lineSel  = SEL_LAST;
          strb.fieldVal = 1'b0;
        end else begin
          strb.lineSel  = SEL_MID;
          strb.fieldVal = 1'b1;
        end
      end
    end
  end

  // R2
  sleep_keeps_std_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_SLEEP) |=> $stable(stdR));

  // R10
  line_load_sets_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineLoad |-> strb.fieldSet && (strb.fieldVal == (strb.lineSel == SEL_MID)));

endmodule

// File: rtl/sync_dp.sv
module sync_dp
  import sync_pkg::*;
#(
  parameter int HSYNC_CLKS   = 64,
  parameter int VSYNC_LINES  = 2,
  parameter int HBLANK_CLKS  = 276,
  parameter int VBLANK_LINES = 20,
  parameter int SAMPLE_W     = 11,
  parameter int LINE_W       = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterSel,
  input  syncStrb_t           strb,
  input  logic [SAMPLE_W-1:0] lineLast,
  input  logic [SAMPLE_W-1:0] lineHalf,
  input  logic [LINE_W-1:0]   frameLast,
  input  logic [LINE_W-1:0]   fieldMid,
  output logic [SAMPLE_W-1:0] sampleR,
  output logic [LINE_W-1:0]   lineR,
  output logic                fieldR,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                syncOe,
  output logic                hBlank,
  output logic                vBlank
);

  localparam logic [SAMPLE_W-1:0] HS_END = SAMPLE_W'(HSYNC_CLKS);
  localparam logic [SAMPLE_W-1:0] HB_END = SAMPLE_W'(HBLANK_CLKS);
  localparam logic [LINE_W-1:0]   VS_N   = LINE_W'(VSYNC_LINES);
  localparam logic [LINE_W-1:0]   VB_N   = LINE_W'(VBLANK_LINES);

  logic [LINE_W-1:0] lineLoadVal, vsEndLine;
  logic              hsActive, vsActive;

  always_comb begin
    unique case (strb.lineSel)
      SEL_MID:  lineLoadVal = fieldMid;
      SEL_LAST: lineLoadVal = frameLast;
      default:  lineLoadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleR <= '0;
      lineR   <= '0;
      fieldR  <= 1'b0;
    end else begin
      sampleR <= strb.sampleClr ? '0 : sampleR + 1'b1;
      if (strb.lineLoad)     lineR <= lineLoadVal;
      else if (strb.lineInc) lineR <= (lineR >= frameLast) ? '0 : lineR + 1'b1;
      if (strb.fieldSet)     fieldR <= strb.fieldVal;
    end
  end

  assign vsEndLine = fieldMid + VS_N;
  assign hsActive  = (sampleR < HS_END);
  assign vsActive  = (lineR < VS_N)
                   || ((lineR == fieldMid) && (sampleR >= lineHalf))
                   || ((lineR > fieldMid) && (lineR < vsEndLine))
                   || ((lineR == vsEndLine) && (sampleR < lineHalf));

  assign syncOe   = masterSel;
  assign hsyncOut = masterSel ? ~hsActive : 1'b1;
  assign vsyncOut = masterSel ? ~vsActive : 1'b1;
  assign hBlank   = (sampleR < HB_END);
  assign vBlank   = (lineR < VB_N) || ((lineR >= fieldMid) && (lineR < fieldMid + VB_N));

  // R8
  sample_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleClr |=> (sampleR == '0));

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterSel |-> (hsyncOut && vsyncOut && !syncOe));

  // R4
  frame_start_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterSel && (sampleR == '0) && (lineR == '0)) |-> !fieldR);

  // R3
  sample_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterSel && (sampleR < lineLast)) |=> (sampleR == $past(sampleR) + 1'b1));

endmodule

// File: rtl/sync_timer.sv
module sync_timer
  import sync_pkg::*;
#(
  parameter int LINE_CLKS_525   = 1716,
  parameter int LINE_CLKS_625   = 1728,
  parameter int FRAME_LINES_525 = 525,
  parameter int FRAME_LINES_625 = 625,
  parameter int HSYNC_CLKS      = 64,
  parameter int VSYNC_LINES     = 2,
  parameter int HBLANK_CLKS     = 276,
  parameter int VBLANK_LINES    = 20,
  localparam int SAMPLE_W = $clog2((LINE_CLKS_625 > LINE_CLKS_525) ? LINE_CLKS_625 : LINE_CLKS_525),
  localparam int LINE_W   = $clog2((FRAME_LINES_625 > FRAME_LINES_525) ? FRAME_LINES_625 : FRAME_LINES_525)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                masterSel,
  input  logic                hsyncIn,
  input  logic                vsyncIn,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                syncOe,
  output logic [SAMPLE_W-1:0] sampleNum,
  output logic [LINE_W-1:0]   lineNum,
  output logic                evenField,
  output logic                hBlank,
  output logic                vBlank,
  output logic                encEnable
);

  syncStrb_t           strb;
  logic [SAMPLE_W-1:0] lineLast, lineHalf;
  logic [LINE_W-1:0]   frameLast, fieldMid;

  sync_ctrl #(
    .LINE_CLKS_525(LINE_CLKS_525), .LINE_CLKS_625(LINE_CLKS_625),
    .FRAME_LINES_525(FRAME_LINES_525), .FRAME_LINES_625(FRAME_LINES_625),
    .SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .masterSel(masterSel),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .sampleR(sampleNum), .lineR(lineNum),
    .strb(strb), .lineLast(lineLast), .lineHalf(lineHalf),
    .frameLast(frameLast), .fieldMid(fieldMid), .encEnable(encEnable)
  );

  sync_dp #(
    .HSYNC_CLKS(HSYNC_CLKS), .VSYNC_LINES(VSYNC_LINES),
    .HBLANK_CLKS(HBLANK_CLKS), .VBLANK_LINES(VBLANK_LINES),
    .SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .masterSel(masterSel), .strb(strb),
    .lineLast(lineLast), .lineHalf(lineHalf), .frameLast(frameLast), .fieldMid(fieldMid),
    .sampleR(sampleNum), .lineR(lineNum), .fieldR(evenField),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .syncOe(syncOe),
    .hBlank(hBlank), .vBlank(vBlank)
  );

endmodule

// File: tb/test_sync_timer.sv
`timescale 1ns/1ps
module test_sync_timer;

  localparam int L5 = 40, L6 = 48, N5 = 11, N6 = 13;
  localparam int HSW = 6, VSL = 2, HBK = 8, VBK = 3;
  localparam int SW = $clog2(L6), LW = $clog2(N6);

  logic          clk = 1'b0;
  logic          rstN, masterSel, hsIn, vsIn;
  logic [1:0]    modeSel;
  logic          hsyncOut, vsyncOut, syncOe, evenField, hBlank, vBlank, encEnable;
  logic [SW-1:0] sampleNum;
  logic [LW-1:0] lineNum;

  int nChk = 0, nFail = 0;
  bit done = 0;
  int mS, mL, mF, mStd;
  int expLine, expField, vsLeft;
  int seedDummy;

  always #2.5 clk = ~clk;

  sync_timer #(
    .LINE_CLKS_525(L5), .LINE_CLKS_625(L6), .FRAME_LINES_525(N5), .FRAME_LINES_625(N6),
    .HSYNC_CLKS(HSW), .VSYNC_LINES(VSL), .HBLANK_CLKS(HBK), .VBLANK_LINES(VBK)
  ) i_sync_timer (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .masterSel(masterSel),
    .hsyncIn(hsIn), .vsyncIn(vsIn), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .syncOe(syncOe), .sampleNum(sampleNum), .lineNum(lineNum), .evenField(evenField),
    .hBlank(hBlank), .vBlank(vBlank), .encEnable(encEnable)
  );

  function automatic int lenOf(int s);   return s ? L6 : L5; endfunction
  function automatic int linesOf(int s); return s ? N6 : N5; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  // master reference step, applied at a rising edge with the inputs of that edge
  task automatic mTick();
    int len, n, pS, pL;
    len = lenOf(mStd); n = linesOf(mStd); pS = mS; pL = mL;
    if (pS >= len - 1) begin
      mS = 0;
      if (pL >= n - 1) begin mL = 0; mF = 0; end
      else mL = pL + 1;
    end else mS = pS + 1;
    if (pL == n / 2 && pS == len / 2 - 1) mF = 1;
    if (modeSel != 2'b00) mStd = (modeSel == 2'b10) ? 1 : 0;
  endtask

  task automatic mCheck();
    int len, n, h, hf;
    bit vAct, hb, vb;
    string tS;
    len = lenOf(mStd); n = linesOf(mStd); h = n / 2; hf = len / 2;
    vAct = (mL < VSL) || (mL == h && mS >= hf) || (mL > h && mL < h + VSL) || (mL == h + VSL && mS < hf);
    hb = (mS < HBK);
    vb = (mL < VBK) || (mL >= h && mL < h + VBK);
    tS = (modeSel == 2'b00) ? "R2 sample in sleep" : "R3 sample";
    chk(tS, sampleNum, mS);
    chk("R4 line", lineNum, mL);
    chk("R4 field", evenField, mF);
    chk("R3 hsync", hsyncOut, (mS < HSW) ? 0 : 1);
    chk("R5 vsync", vsyncOut, vAct ? 0 : 1);
    chk("R6 hblank", hBlank, hb);
    chk("R6 vblank", vBlank, vb);
    chk("R7 oe master", syncOe, 1);
    chk((modeSel == 2'b00) ? "R2 enable" : "R1 enable", encEnable, (modeSel != 2'b00) ? 1 : 0);
  endtask

  task automatic mRun(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); mTick();
      @(negedge clk); mCheck();
    end
  endtask

  task automatic runFrame(input int m);
    int s;
    modeSel = m[1:0];
    s = (m == 0) ? mStd : ((m == 2) ? 1 : 0);
    mRun(lenOf(s) * linesOf(s));
  endtask

  // one slave line: horizontal edge at k=0, optional vertical edge at k=vsAt
  task automatic slaveLine(input int vsAt);
    string tg;
    for (int k = 0; k < L5; k++) begin
      hsIn = (k < HSW) ? 1'b0 : 1'b1;
      if (k == vsAt) vsLeft = L5;
      vsIn = (vsLeft > 0) ? 1'b0 : 1'b1;
      if (vsLeft > 0) vsLeft--;
      if (k == 0) begin
        tg = "R8 line";
        if (vsAt == 0) begin expLine = 0; expField = 0; tg = "R9 line"; end
        else expLine = (expLine + 1) % N5;
      end else if (k == vsAt) begin
        int p;
        p = k - 1;
        if (p < L5 / 4) begin expLine = 0; expField = 0; tg = "R11 early line"; end
        else if (p >= (3 * L5) / 4) begin expLine = N5 - 1; expField = 0; tg = "R11 late line"; end
        else begin expLine = N5 / 2; expField = 1; tg = "R10 mid line"; end
      end else tg = "R8 line";
      @(posedge clk);
      @(negedge clk);
      chk("R8 sample", sampleNum, k);
      chk(tg, lineNum, expLine);
      chk(tg, evenField, expField);
      chk("R7 slave hsync", hsyncOut, 1);
      chk("R7 slave vsync", vsyncOut, 1);
      chk("R7 oe slave", syncOe, 0);
    end
  endtask

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    seedDummy = $urandom(32'd2024);
    rstN = 1'b0; modeSel = 2'b11; masterSel = 1'b1; hsIn = 1'b1; vsIn = 1'b1; vsLeft = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 sample", sampleNum, 0);
    chk("R12 line", lineNum, 0);
    chk("R12 field", evenField, 0);
    mS = 0; mL = 0; mF = 0; mStd = 0;
    rstN = 1'b1;
    // R1 525-line master, two frames
    mRun(2 * L5 * N5);
    // directed: 625 lines, sleep keeps 625 (R2), then the other 525-line code
    runFrame(2);
    runFrame(0);
    runFrame(1);
    runFrame(0);
    // random standard sequence
    for (int i = 0; i < 6; i++) runFrame(int'($urandom % 4));
    // slave section on the 525-line standard
    modeSel = 2'b11;
    mRun(L5 * N5);
    masterSel = 1'b0;
    repeat (3) @(negedge clk);
    slaveLine(0);
    slaveLine(-1);
    slaveLine(-1);
    slaveLine(L5 / 2 + 1);
    slaveLine(-1);
    slaveLine(3);
    slaveLine(-1);
    slaveLine(L5 - 2);
    slaveLine(-1);
    slaveLine(L5 / 4 + 1);
    slaveLine(-1);
    slaveLine((3 * L5) / 4 + 1);
    slaveLine(-1);
    for (int i = 0; i < 8; i++) begin
      slaveLine(int'($urandom % L5));
      slaveLine(-1);
    end
    summary();
  end

endmodule